// File: doc/BRIEF.md
# UART Bit-Rate Generator with Idle Timeout

This block derives the per-bit timing strobe of a serial port from the core clock and watches the receive side for silence. The clock first passes an optional fixed pre-divider, selected by bit 0 of the mode word. It then goes through a programmable baud counter and finally through a per-bit sample divider. The result is a one-cycle strobe, `baud_tick_o`, at the bit rate.

The same mode word is decoded into frame parameters: data length, parity enable and sense, stop-bit count, and the total number of bit times in one character. After each received byte, an idle timer counts bit strobes. If no further byte arrives within four character times, it emits a single-cycle timeout pulse.

A serializer or deserializer elsewhere uses the strobe and the frame parameters, and reports each accepted byte on `rx_byte_i`.

Top module: `uart_bitrate_timer`

## Requirements
- R1: With `mode_i[0]` = 1 the clock is divided by 8 ahead of the baud counter. With `mode_i[0]` = 0 the baud counter advances on every clock.
- R2: With baud count C > 0 and sample divider D, `baud_tick_o` is a one-cycle pulse with period P = pre × C × (D+1) clocks, where pre is 8 or 1. It first rises after the P-th clock edge following reset release.
- R3: A baud count of 0 stops the strobe. `baud_tick_o` stays low and no timeout can occur.
- R4: `data_bits_o` is 6 when `mode_i[2:1]` = 11, 7 when it is 10, and 8 for any other value.
- R5: `mode_i[5:3]` = 000 gives even parity (`parity_en_o`=1, `parity_odd_o`=0). A value of 001 gives odd parity (both 1). Any other value gives no parity (both 0).
- R6: `stop_bits_o` is 1 when `mode_i[7:6]` = 11 and 2 otherwise.
- R7: `char_bits_o` = 1 + `parity_en_o` + `data_bits_o` + `stop_bits_o`.
- R8: After a byte, when 4 × `char_bits_o` strobes have been counted with no further byte, `rx_timeout_o` pulses high for exactly one cycle. The pulse appears on the cycle after the edge at which the last counted strobe was high.
- R9: Every `rx_byte_i` pulse restarts the idle count from zero. A strobe that coincides with a byte is not counted.
- R10: No timeout is produced after reset until a byte has been seen. After a timeout, none follows until another byte arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_i | input | 8 | Mode word: pre-divide select, data length, parity, stop bits |
| baud_cnt_i | input | CNT_W (16) | Baud counter terminal count, 0 stops the strobe |
| sample_div_i | input | DIV_W (8) | Sample divider; bit period is value+1 counter periods |
| rx_byte_i | input | 1 | One-cycle pulse per received byte |
| baud_tick_o | output | 1 | Bit-rate strobe |
| data_bits_o | output | 4 | Decoded data length |
| parity_en_o | output | 1 | Parity bit present |
| parity_odd_o | output | 1 | Odd parity selected |
| stop_bits_o | output | 2 | Decoded stop-bit count |
| char_bits_o | output | 4 | Bit times per character |
| rx_timeout_o | output | 1 | Receive idle timeout pulse |

## Verification
The strobe-spacing property assumes that the pre-divide select stays put across the cycles it looks at. The stimulus therefore changes divider settings only while reset is held, and the bench's period model also relies on that. The timeout properties take `rx_byte_i` to be a clean one-cycle pulse, driven away from the clock edge. The mode word is swept freely only with the baud count at zero, so decode changes cannot disturb the strobe phase.

// File: rtl/uart_bt_pkg.sv
package uart_bt_pkg;
   localparam int MAX_CHAR_BITS = 12;

   typedef struct packed {
      logic [3:0] data_bits;
      logic       par_en;
      logic       par_odd;
      logic [1:0] stop_bits;
      logic [3:0] char_bits;
   } frame_cfg_t;
endpackage

// File: rtl/uart_frame_decode.sv
module uart_frame_decode
   import uart_bt_pkg::*;
(
   input  logic [7:0] mode_i,
   output frame_cfg_t cfg_o
);
   always_comb begin
      cfg_o = '0;
      unique case (mode_i[2:1])
         2'b11:   cfg_o.data_bits = 4'd6;
         2'b10:   cfg_o.data_bits = 4'd7;
         default: cfg_o.data_bits = 4'd8;
      endcase
      cfg_o.par_en  = (mode_i[5:4] == 2'b00);
      cfg_o.par_odd = (mode_i[5:3] == 3'b001);
      cfg_o.stop_bits = (mode_i[7:6] == 2'b11) ? 2'd1 : 2'd2;
      cfg_o.char_bits = 4'd1 + {3'd0, cfg_o.par_en} + cfg_o.data_bits
                        + {2'd0, cfg_o.stop_bits};
   end
endmodule

// File: rtl/uart_baud_chain.sv
module uart_baud_chain #(
   parameter int CNT_W     = 16,
   parameter int DIV_W     = 8,
   parameter int PRE_RATIO = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pre_sel,
   input  logic [CNT_W-1:0] baud_cnt,
   input  logic [DIV_W-1:0] sample_div,
   output logic             tick_o
);
   logic pre_en;
   logic run;
   logic samp;
   logic last;
   logic [CNT_W-1:0] bcnt_q;
   logic [DIV_W-1:0] sdiv_q;

   generate
      if (PRE_RATIO > 1) begin : g_pre
         localparam int PRE_W = $clog2(PRE_RATIO);
         logic [PRE_W-1:0] pre_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        pre_q <= '0;
            else if (!pre_sel) pre_q <= '0;
            else               pre_q <= pre_q + 1'b1;
         end
         assign pre_en = !pre_sel || (pre_q == PRE_W'(PRE_RATIO - 1));
      end else begin : g_nopre
         assign pre_en = 1'b1;
      end
   endgenerate

   assign run  = (baud_cnt != '0);
   assign samp = run && pre_en && (bcnt_q >= baud_cnt - 1'b1);
   assign last = (sdiv_q >= sample_div);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bcnt_q <= '0;
         sdiv_q <= '0;
         tick_o <= 1'b0;
      end else begin
         tick_o <= samp && last;
         if (!run) begin
            bcnt_q <= '0;
            sdiv_q <= '0;
         end else begin
            if (pre_en) bcnt_q <= samp ? '0 : bcnt_q + 1'b1;
            if (samp)   sdiv_q <= last ? '0 : sdiv_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/uart_idle_timer.sv
module uart_idle_timer #(
   parameter int CW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          rx_byte,
   input  logic [CW-1:0] limit,
   output logic          to_o
);
   logic          armed_q;
   logic [CW-1:0] cnt_q;
   logic          hit;

   assign hit = armed_q && tick && (cnt_q >= limit - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         cnt_q   <= '0;
         to_o    <= 1'b0;
      end else begin
         to_o <= 1'b0;
         if (rx_byte) begin
            armed_q <= 1'b1;
            cnt_q   <= '0;
         end else if (hit) begin
            armed_q <= 1'b0;
            cnt_q   <= '0;
            to_o    <= 1'b1;
         end else if (armed_q && tick) begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/uart_bitrate_timer.sv
module uart_bitrate_timer
   import uart_bt_pkg::*;
#(
   parameter int CNT_W     = 16,
   parameter int DIV_W     = 8,
   parameter int PRE_RATIO = 8,
   parameter int TO_CHARS  = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [7:0]       mode_i,
   input  logic [CNT_W-1:0] baud_cnt_i,
   input  logic [DIV_W-1:0] sample_div_i,
   input  logic             rx_byte_i,
   output logic             baud_tick_o,
   output logic [3:0]       data_bits_o,
   output logic             parity_en_o,
   output logic             parity_odd_o,
   output logic [1:0]       stop_bits_o,
   output logic [3:0]       char_bits_o,
   output logic             rx_timeout_o
);
   localparam int TO_W = $clog2(TO_CHARS * MAX_CHAR_BITS + 1);

   generate
      if (PRE_RATIO < 1 || (PRE_RATIO & (PRE_RATIO - 1)) != 0) begin : g_bad_pre
         $error("PRE_RATIO must be a power of two");
      end
      if (TO_CHARS < 1) begin : g_bad_to
         $error("TO_CHARS must be at least 1");
      end
      if (CNT_W < 1 || DIV_W < 1) begin : g_bad_w
         $error("counter widths must be positive");
      end
   endgenerate

   frame_cfg_t       cfg;
   logic [TO_W-1:0]  to_limit;

   uart_frame_decode u_dec (
      .mode_i (mode_i),
      .cfg_o  (cfg)
   );

   uart_baud_chain #(
      .CNT_W     (CNT_W),
      .DIV_W     (DIV_W),
      .PRE_RATIO (PRE_RATIO)
   ) u_chain (
      .clk        (clk),
      .rst_n      (rst_n),
      .pre_sel    (mode_i[0]),
      .baud_cnt   (baud_cnt_i),
      .sample_div (sample_div_i),
      .tick_o     (baud_tick_o)
   );

   assign to_limit = TO_W'(TO_CHARS) * TO_W'(cfg.char_bits);

   uart_idle_timer #(
      .CW (TO_W)
   ) u_idle (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (baud_tick_o),
      .rx_byte (rx_byte_i),
      .limit   (to_limit),
      .to_o    (rx_timeout_o)
   );

   assign data_bits_o  = cfg.data_bits;
   assign parity_en_o  = cfg.par_en;
   assign parity_odd_o = cfg.par_odd;
   assign stop_bits_o  = cfg.stop_bits;
   assign char_bits_o  = cfg.char_bits;
endmodule

// File: rtl/uart_bitrate_timer_chk.sv
module uart_bitrate_timer_chk #(
   parameter int CNT_W = 16,
   parameter int DIV_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic [7:0]       mode_i,
   input logic [CNT_W-1:0] baud_cnt_i,
   input logic [DIV_W-1:0] sample_div_i,
   input logic             rx_byte_i,
   input logic             baud_tick_o,
   input logic [3:0]       data_bits_o,
   input logic             parity_en_o,
   input logic             parity_odd_o,
   input logic [1:0]       stop_bits_o,
   input logic [3:0]       char_bits_o,
   input logic             rx_timeout_o
);
   logic seen_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) seen_q <= 1'b0;
      else        seen_q <= seen_q | rx_byte_i;
   end

   p_prediv_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(mode_i[0]) && mode_i[0] && baud_tick_o) |=> !baud_tick_o);

   p_stop_no_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(baud_cnt_i) == '0) |-> !baud_tick_o);

   p_data_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
      data_bits_o inside {4'd6, 4'd7, 4'd8});

   p_parity_r5: assert property (@(posedge clk) disable iff (!rst_n)
      parity_odd_o |-> parity_en_o);

   p_stop_cnt_r6: assert property (@(posedge clk) disable iff (!rst_n)
      stop_bits_o inside {2'd1, 2'd2});

   p_char_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
      char_bits_o inside {[4'd8:4'd12]});

   p_to_after_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rx_timeout_o |-> ($past(baud_tick_o) && !$past(rx_byte_i)));

   p_to_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rx_timeout_o |=> !rx_timeout_o);

   p_rx_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rx_byte_i |=> !rx_timeout_o);

   p_to_needs_byte_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rx_timeout_o |-> seen_q);
endmodule

bind uart_bitrate_timer uart_bitrate_timer_chk #(
   .CNT_W (CNT_W),
   .DIV_W (DIV_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .mode_i       (mode_i),
   .baud_cnt_i   (baud_cnt_i),
   .sample_div_i (sample_div_i),
   .rx_byte_i    (rx_byte_i),
   .baud_tick_o  (baud_tick_o),
   .data_bits_o  (data_bits_o),
   .parity_en_o  (parity_en_o),
   .parity_odd_o (parity_odd_o),
   .stop_bits_o  (stop_bits_o),
   .char_bits_o  (char_bits_o),
   .rx_timeout_o (rx_timeout_o)
);

// File: tb/sim_uart_bitrate_timer.sv
module sim_uart_bitrate_timer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  mode = 8'h00;
   logic [15:0] bcnt = 16'd0;
   logic [7:0]  sdiv = 8'd0;
   logic        rx = 1'b0;
   logic        tick;
   logic [3:0]  dbits;
   logic        pen;
   logic        podd;
   logic [1:0]  sbits;
   logic [3:0]  cbits;
   logic        tout;

   int total = 0;
   int bad = 0;
   int cyc = 0;

   // reference model state
   int    e_cnt;
   bit    m_tick;
   bit    m_armed;
   int    m_seen;
   bit    m_to;
   string to_tag = "R8";

   always #4 clk = ~clk;

   uart_bitrate_timer u0 (
      .clk (clk), .rst_n (rst_n), .mode_i (mode), .baud_cnt_i (bcnt),
      .sample_div_i (sdiv), .rx_byte_i (rx), .baud_tick_o (tick),
      .data_bits_o (dbits), .parity_en_o (pen), .parity_odd_o (podd),
      .stop_bits_o (sbits), .char_bits_o (cbits), .rx_timeout_o (tout)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s act=%0d exp=%0d t=%0t", req, what, act, exp, $time);
      end
   endtask

   function automatic int exp_data(input logic [7:0] m);
      if (m[2] && m[1]) return 6;
      if (m[2])         return 7;
      return 8;
   endfunction
   function automatic int exp_pen(input logic [7:0] m);
      return (m[5:3] == 3'd0 || m[5:3] == 3'd1) ? 1 : 0;
   endfunction
   function automatic int exp_podd(input logic [7:0] m);
      return (m[5:3] == 3'd1) ? 1 : 0;
   endfunction
   function automatic int exp_stop(input logic [7:0] m);
      return (m[7:6] == 2'b11) ? 1 : 2;
   endfunction
   function automatic int exp_char(input logic [7:0] m);
      return 1 + exp_pen(m) + exp_data(m) + exp_stop(m);
   endfunction

   task automatic model_edge();
      int period;
      bit prev_tick;
      prev_tick = m_tick;
      e_cnt++;
      period = (mode[0] ? 8 : 1) * int'(bcnt) * (int'(sdiv) + 1);
      m_tick = (bcnt != 0) && (e_cnt % period == 0);
      m_to = 0;
      if (rx) begin
         m_armed = 1;
         m_seen = 0;
      end else if (m_armed && prev_tick) begin
         m_seen++;
         if (m_seen == 4 * exp_char(mode)) begin
            m_to = 1;
            m_armed = 0;
            m_seen = 0;
         end
      end
   endtask

   task automatic compare();
      string treq;
      treq = (bcnt == 0) ? "R3" : (mode[0] ? "R1" : "R2");
      check(treq, "baud_tick", int'(tick), int'(m_tick));
      check(to_tag, "rx_timeout", int'(tout), int'(m_to));
      check("R4", "data_bits", int'(dbits), exp_data(mode));
      check("R5", "parity_en", int'(pen), exp_pen(mode));
      check("R5", "parity_odd", int'(podd), exp_podd(mode));
      check("R6", "stop_bits", int'(sbits), exp_stop(mode));
      check("R7", "char_bits", int'(cbits), exp_char(mode));
   endtask

   task automatic step(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         model_edge();
         @(negedge clk);
         compare();
      end
   endtask

   task automatic byte_in();
      rx = 1'b1;
      step(1);
      rx = 1'b0;
   endtask

   task automatic restart(input logic [7:0] m, input int c, input int d);
      @(negedge clk);
      rst_n = 1'b0;
      rx = 1'b0;
      mode = m;
      bcnt = 16'(c);
      sdiv = 8'(d);
      @(negedge clk);
      @(negedge clk);
      check("R2", "reset tick", int'(tick), 0);
      check("R10", "reset timeout", int'(tout), 0);
      rst_n = 1'b1;
      e_cnt = 0; m_tick = 0; m_armed = 0; m_seen = 0; m_to = 0;
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cyc++;
         if (cyc > 150000) begin
            bad++;
            total++;
            $display("FAIL R2 watchdog act=%0d exp=finish", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
         end
      end
   end

   initial begin
      // R2: 8 data, even parity, 2 stop -> 12 bits/char; P = 3*2 = 6
      restart(8'h00, 3, 1);
      to_tag = "R10";            // R10: no byte yet, no timeout
      step(200);
      to_tag = "R8";             // R8: 48 strobes after byte
      byte_in();
      step(350);
      to_tag = "R9";             // R9: second byte restarts the count
      byte_in();
      step(150);
      byte_in();
      step(350);
      to_tag = "R10";            // R10: after timeout, silence stays silent
      step(400);

      // R1: pre-divide by 8, 6 data, odd, 1 stop -> 9 bits; P = 8*2*3 = 48
      restart(8'b11_001_11_1, 2, 2);
      to_tag = "R8";
      byte_in();
      step(1900);

      // R3: baud count zero, no strobe, no timeout
      restart(8'h00, 0, 3);
      to_tag = "R3";
      byte_in();
      step(300);

      // R2: fastest setting P = 1; 7 data, no parity, 2 stop -> 10 bits
      restart(8'b10_010_10_0, 1, 0);
      to_tag = "R8";
      byte_in();
      step(60);
      to_tag = "R9";             // R9: byte back-to-back
      byte_in();
      byte_in();
      step(60);

      // R10: reset while armed clears the pending timeout
      restart(8'h00, 1, 0);
      byte_in();
      step(20);
      restart(8'h00, 1, 0);
      to_tag = "R10";
      step(100);

      // R4 R5 R6 R7: sweep every mode word with the strobe stopped
      restart(8'h00, 0, 0);
      to_tag = "R3";
      for (int m = 0; m < 256; m++) begin
         mode = 8'(m);
         step(1);
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule